// File: doc/BRIEF.md
# Buffered Program Sequence Tracker

This block sits beside a flash command interpreter and follows the multi-write sequence that loads a small page buffer before a program operation. It watches the write bus. After the two unlock writes, a load command at a sector address opens the sequence. The next write, to the same sector, gives the word count minus one. That many address/data writes follow, and each one is stored in a 16-word page buffer. A confirm command at the sector address closes the sequence. A correct sequence produces a one-cycle commit pulse. During that pulse the outputs show the page base address, every buffered word and a mask of the slots that were written.

The tracker catches sequences that break the rules: a word count too large for the page, a word outside the page of the first program address, a word-count write to another sector, or a bad confirm. Any of these puts it into a sticky abort state. In that state only the three-write abort-reset sequence does anything. Programming of the array lies outside this block.

Top module: `bufprog_tracker`

## Requirements
- R1: After reset, `abortFlag` is 0, `commitPulse` is 0 and `commitMask` is all zero.
- R2: A load opens only after the writes data AA to address 555, data 55 to address 2AA, then data 25 to any address, which becomes the sector address. The sector is the address bits from bit 15 upward. If the first two writes are broken, the tracker goes back to waiting and does not abort. A broken write that is itself AA/555 counts as a new first unlock write.
- R3: The write after the load command sets the word count (words minus one) from the full data word. A count above 15, or a sector that differs from the load command's sector, raises `abortFlag` after that write.
- R4: Each program write stores its data at the slot given by address bits 3:0 and sets that bit in `commitMask`. A repeated slot keeps the last data. The load command clears `commitMask`.
- R5: The first program write fixes the page, which is address bits 4 and up. A later program write outside that page raises `abortFlag`.
- R6: After count+1 program writes, data 29 written to the load sector ends the load. In the following cycle `commitPulse` is 1 for exactly one cycle. `commitBase` is the first program address with bits 3:0 cleared, `commitMask` has the stored slots set, and the words in `commitData` (slot i at bits 16i+15:16i) are the stored data.
- R7: If the write after the last program word is not data 29, or goes to another sector, `abortFlag` rises and no commit pulse follows.
- R8: While `abortFlag` is 1, every write is ignored except the sequence AA/555, 55/2AA, F0/555. That sequence clears `abortFlag`, and a new load then works normally.
- R9: Bus values presented while `wrEn` is 0 have no effect on any output.
- R10: Command matching uses only address bits 11:0 and data bits 7:0. Higher bits are don't care.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe, one write per cycle |
| wrAddr | input | 22 | Write address |
| wrData | input | 16 | Write data |
| commitPulse | output | 1 | One-cycle pulse when a load is confirmed |
| commitBase | output | 22 | Page base address of the committed load |
| commitData | output | 256 | Buffered words, slot i at bits 16i+15:16i |
| commitMask | output | 16 | Slots written during the current load |
| abortFlag | output | 1 | Sticky abort state |

## Verification
The bench targets the edges of the word count. The largest count (15) fills all sixteen slots; a design that misplaces the end of the count would ask for the confirm one word early or one word late, and the commit would either fail to pulse or abort. A count of 16 must abort; a design that checked only the low four bits would accept it as zero. It also breaks the abort-reset sequence part-way and sends a full load sequence while aborted. A design that let commands through in the abort state would clear the mask or pulse commit. The bench also writes high address and data bits during command writes, repeats a slot, and drives command values with the strobe low.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_COUNT,
    ST_WORDS,
    ST_CONFIRM,
    ST_ABT0,
    ST_ABT1,
    ST_ABT2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchSector;  // load command accepted: keep sector, clear mask
    logic latchPage;    // first program word: keep page tag
    logic storeWord;    // write data into the addressed slot
  } dpStrobe_t;

  // datapath -> control decode results
  typedef struct packed {
    logic unlockA;      // AA at 555
    logic unlockB;      // 55 at 2AA
    logic resetCmd;     // F0 at 555
    logic loadCmd;      // 25
    logic confirmCmd;   // 29
    logic sectorMatch;  // address in the latched sector
    logic pageMatch;    // address in the latched page
    logic countTooBig;  // word count beyond page size
  } dpMatch_t;

endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bufprog_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int SECT_LSB   = 15,
  parameter int CMD_AW     = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  dpStrobe_t                    strobe,
  output dpMatch_t                     match,
  output logic [ADDR_W-1:0]            commitBase,
  output logic [PAGE_WORDS*DATA_W-1:0] commitData,
  output logic [PAGE_WORDS-1:0]        commitMask
);

  localparam int PAGE_AW = $clog2(PAGE_WORDS);
  localparam int TAG_W   = ADDR_W - PAGE_AW;
  localparam int SECT_W  = ADDR_W - SECT_LSB;

  logic [SECT_W-1:0]     sectorQ;
  logic [TAG_W-1:0]      pageQ;
  logic [PAGE_WORDS-1:0] maskQ;
  logic [PAGE_AW-1:0]    slotIdx;

  assign slotIdx = wrAddr[PAGE_AW-1:0];

  // command decode on the low address and data bits only
  always_comb begin
    match.unlockA     = (wrAddr[CMD_AW-1:0] == CMD_AW'('h555)) && (wrData[7:0] == 8'hAA);
    match.unlockB     = (wrAddr[CMD_AW-1:0] == CMD_AW'('h2AA)) && (wrData[7:0] == 8'h55);
    match.resetCmd    = (wrAddr[CMD_AW-1:0] == CMD_AW'('h555)) && (wrData[7:0] == 8'hF0);
    match.loadCmd     = (wrData[7:0] == 8'h25);
    match.confirmCmd  = (wrData[7:0] == 8'h29);
    match.sectorMatch = (wrAddr[ADDR_W-1:SECT_LSB] == sectorQ);
    match.pageMatch   = (wrAddr[ADDR_W-1:PAGE_AW] == pageQ);
    match.countTooBig = (wrData > DATA_W'(PAGE_WORDS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorQ <= '0;
      pageQ   <= '0;
      maskQ   <= '0;
    end else begin
      if (strobe.latchSector) sectorQ <= wrAddr[ADDR_W-1:SECT_LSB];
      if (strobe.latchPage)   pageQ   <= wrAddr[ADDR_W-1:PAGE_AW];
      if (strobe.latchSector)    maskQ          <= '0;
      else if (strobe.storeWord) maskQ[slotIdx] <= 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < PAGE_WORDS; gi++) begin : gSlot
      logic [DATA_W-1:0] wordQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          wordQ <= '0;
        else if (strobe.storeWord && (slotIdx == PAGE_AW'(gi)))
          wordQ <= wrData;
      end
      assign commitData[gi*DATA_W +: DATA_W] = wordQ;
    end
  endgenerate

  assign commitBase = {pageQ, {PAGE_AW{1'b0}}};
  assign commitMask = maskQ;

  AST_STORE_IN_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeWord && !strobe.latchPage) |-> match.pageMatch); // R5

  AST_STORE_SETS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeWord && !strobe.latchSector) |=> commitMask[$past(slotIdx)]); // R4

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeWord || strobe.latchSector) |-> wrEn); // R9

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bufprog_pkg::*;
#(
  parameter int PAGE_WORDS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [$clog2(PAGE_WORDS)-1:0] wrCount,
  input  dpMatch_t                     match,
  output dpStrobe_t                    strobe,
  output logic                         commitPulse,
  output logic                         abortFlag
);

  localparam int PAGE_AW = $clog2(PAGE_WORDS);

  seqState_t          stateQ, stateD;
  logic [PAGE_AW-1:0] leftQ, leftD;
  logic               firstQ, firstD;
  logic               fire;
  logic               inAbort;

  always_comb begin
    stateD = stateQ;
    leftD  = leftQ;
    firstD = firstQ;
    strobe = '0;
    fire   = 1'b0;
    if (wrEn) begin
      case (stateQ)
        ST_IDLE:
          if (match.unlockA) stateD = ST_UNLK1;
        ST_UNLK1:
          if (match.unlockB)      stateD = ST_UNLK2;
          else if (match.unlockA) stateD = ST_UNLK1;
          else                    stateD = ST_IDLE;
        ST_UNLK2:
          if (match.loadCmd) begin
            stateD             = ST_COUNT;
            strobe.latchSector = 1'b1;
          end else if (match.unlockA) stateD = ST_UNLK1;
          else                        stateD = ST_IDLE;
        ST_COUNT:
          if (!match.sectorMatch || match.countTooBig) stateD = ST_ABT0;
          else begin
            stateD = ST_WORDS;
            leftD  = wrCount;
            firstD = 1'b1;
          end
        ST_WORDS:
          if (!firstQ && !match.pageMatch) stateD = ST_ABT0;
          else begin
            strobe.storeWord = 1'b1;
            strobe.latchPage = firstQ;
            firstD           = 1'b0;
            if (leftQ == '0) stateD = ST_CONFIRM;
            else             leftD  = leftQ - 1'b1;
          end
        ST_CONFIRM:
          if (match.confirmCmd && match.sectorMatch) begin
            stateD = ST_IDLE;
            fire   = 1'b1;
          end else stateD = ST_ABT0;
        ST_ABT0:
          if (match.unlockA) stateD = ST_ABT1;
        ST_ABT1:
          if (match.unlockB)      stateD = ST_ABT2;
          else if (match.unlockA) stateD = ST_ABT1;
          else                    stateD = ST_ABT0;
        ST_ABT2:
          if (match.resetCmd)     stateD = ST_IDLE;
          else if (match.unlockA) stateD = ST_ABT1;
          else                    stateD = ST_ABT0;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      leftQ       <= '0;
      firstQ      <= 1'b0;
      commitPulse <= 1'b0;
    end else begin
      stateQ      <= stateD;
      leftQ       <= leftD;
      firstQ      <= firstD;
      commitPulse <= fire;
    end
  end

  assign inAbort   = (stateQ == ST_ABT0) || (stateQ == ST_ABT1) || (stateQ == ST_ABT2);
  assign abortFlag = inAbort;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse); // R6

  AST_PULSE_NOT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !abortFlag); // R7

  AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> $past(wrEn)); // R3

  AST_ABORT_EXIT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(abortFlag) |-> $past(wrEn && match.resetCmd)); // R8

  AST_NO_STORE_IN_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    abortFlag |-> !(strobe.storeWord || strobe.latchSector)); // R8

endmodule

// File: rtl/bufprog_tracker.sv
module bufprog_tracker
  import bufprog_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int SECT_LSB   = 15
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic                         commitPulse,
  output logic [ADDR_W-1:0]            commitBase,
  output logic [PAGE_WORDS*DATA_W-1:0] commitData,
  output logic [PAGE_WORDS-1:0]        commitMask,
  output logic                         abortFlag
);

  localparam int PAGE_AW = $clog2(PAGE_WORDS);

  dpStrobe_t strobe;
  dpMatch_t  match;

  bp_ctrl #(
    .PAGE_WORDS(PAGE_WORDS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrCount    (wrData[PAGE_AW-1:0]),
    .match      (match),
    .strobe     (strobe),
    .commitPulse(commitPulse),
    .abortFlag  (abortFlag)
  );

  bp_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_WORDS(PAGE_WORDS),
    .SECT_LSB  (SECT_LSB)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .match     (match),
    .commitBase(commitBase),
    .commitData(commitData),
    .commitMask(commitMask)
  );

  AST_COMMIT_HAS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (commitMask != '0)); // R6

endmodule

// File: tb/test_bufprog_tracker.sv
module test_bufprog_tracker;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int PW = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [AW-1:0]  wrAddr = '0;
  logic [DW-1:0]  wrData = '0;
  logic           commitPulse;
  logic [AW-1:0]  commitBase;
  logic [PW*DW-1:0] commitData;
  logic [PW-1:0]  commitMask;
  logic           abortFlag;

  bufprog_tracker i_bufprog_tracker (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .commitPulse(commitPulse), .commitBase(commitBase), .commitData(commitData),
    .commitMask(commitMask), .abortFlag(abortFlag)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference model
  int mode = 0;          // 0..2 unlock, 3 count, 4 words, 5 confirm, 6..8 abort-reset steps
  int mSector = 0;
  int mPage = 0;
  int mLeft = 0;
  bit mFirst = 0;
  bit expPulse = 0;
  bit [PW-1:0] expMask = '0;
  int expWord[PW];

  function automatic bit isA(int a, int d);
    return ((a & 'hFFF) == 'h555) && ((d & 'hFF) == 'hAA);
  endfunction
  function automatic bit isB(int a, int d);
    return ((a & 'hFFF) == 'h2AA) && ((d & 'hFF) == 'h55);
  endfunction

  always @(posedge clk) begin
    int a, d;
    if (!rstN) begin
      mode = 0; expPulse = 0; expMask = '0; mFirst = 0;
      for (int i = 0; i < PW; i++) expWord[i] = 0;
    end else begin
      expPulse = 0;
      if (wrEn) begin
        a = int'(wrAddr); d = int'(wrData);
        case (mode)
          0: if (isA(a, d)) mode = 1;
          1: mode = isB(a, d) ? 2 : (isA(a, d) ? 1 : 0);
          2: if ((d & 'hFF) == 'h25) begin mode = 3; mSector = a >> 15; expMask = '0; end
             else mode = isA(a, d) ? 1 : 0;
          3: if ((a >> 15) != mSector || d > PW - 1) mode = 6;
             else begin mLeft = d + 1; mFirst = 1; mode = 4; end
          4: if (!mFirst && (a >> 4) != mPage) mode = 6;
             else begin
               if (mFirst) mPage = a >> 4;
               mFirst = 0;
               expWord[a & 'hF] = d;
               expMask[a & 'hF] = 1'b1;
               mLeft--;
               if (mLeft == 0) mode = 5;
             end
          5: if ((d & 'hFF) == 'h29 && (a >> 15) == mSector) begin expPulse = 1; mode = 0; end
             else mode = 6;
          6: if (isA(a, d)) mode = 7;
          7: mode = isB(a, d) ? 8 : (isA(a, d) ? 7 : 6);
          8: if ((a & 'hFFF) == 'h555 && (d & 'hFF) == 'hF0) mode = 0;
             else mode = isA(a, d) ? 7 : 6;
          default: mode = 0;
        endcase
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "abortFlag", abortFlag, (mode >= 6));
      check(curReq, "commitPulse", commitPulse, expPulse);
      check(curReq, "commitMask", commitMask, expMask);
      if (expPulse) begin
        check(curReq, "commitBase", commitBase, mPage << 4);
        for (int i = 0; i < PW; i++)
          if (expMask[i]) check(curReq, "commitData", commitData[i*DW +: DW], expWord[i]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    wrAddr = AW'(a); wrData = DW'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlockLoad(int sa);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr(sa, 'h25);
  endtask

  task automatic recover();
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++; if (abortFlag !== 1'b0 || commitPulse !== 1'b0 || commitMask !== '0) begin
      fails++; $display("FAIL R1 reset outputs actual=%b%b%h expected=00 0000", abortFlag, commitPulse, commitMask);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2 R6: four words, commit
    curReq = "R6";
    unlockLoad('h18000); wr('h18000, 3);
    for (int k = 0; k < 4; k++) wr('h18040 + k * 3, 'h1000 + k);
    wr('h18123, 'h29);
    @(negedge clk);

    // R4: repeated slot keeps last data
    curReq = "R4";
    unlockLoad('h08000); wr('h08000, 2);
    wr('h08205, 'hAAAA); wr('h08207, 'hBBBB); wr('h08205, 'hCCCC);
    wr('h08000, 'h29);
    @(negedge clk);

    // R2: broken prefix returns to waiting, no abort
    curReq = "R2";
    wr('h555, 'hAA); wr('h2AA, 'h12); wr('h18000, 'h25);
    wr('h555, 'hAA); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h18000, 'h30);
    unlockLoad('h10000); wr('h10000, 0); wr('h10011, 'h5A5A); wr('h10000, 'h29);

    // R10: high address and data bits ignored in commands
    curReq = "R10";
    wr('h3FF555, 'h77AA); wr('h1F2AA, 'h3355); wr('h20000, 'hFF25);
    wr('h20000, 1); wr('h20039, 'h1234); wr('h2003A, 'h4321); wr('h27000, 'h1129);
    @(negedge clk);

    // R3: count of 16 aborts; R8 ignore and recover
    curReq = "R3";
    unlockLoad('h18000); wr('h18000, 16);
    curReq = "R8";
    wr('h18000, 'h29);
    unlockLoad('h18000); wr('h18000, 1); wr('h18040, 1); wr('h18041, 2); wr('h18000, 'h29);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h00);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hF0);
    unlockLoad('h18000); wr('h18000, 0); wr('h18055, 'h9999); wr('h18000, 'h29);

    // R3: count written to another sector
    curReq = "R3";
    unlockLoad('h18000); wr('h20000, 1);
    recover();

    // R5: word outside the page
    curReq = "R5";
    unlockLoad('h18000); wr('h18000, 3); wr('h18040, 1); wr('h18050, 2);
    recover();

    // R7: wrong confirm data, then wrong confirm sector
    curReq = "R7";
    unlockLoad('h18000); wr('h18000, 0); wr('h18040, 1); wr('h18000, 'h30);
    recover();
    unlockLoad('h18000); wr('h18000, 0); wr('h18040, 1); wr('h20000, 'h29);
    recover();
    @(negedge clk);

    // R6: full page of 16 words
    curReq = "R6";
    unlockLoad('h38000); wr('h38000, 15);
    for (int k = 15; k >= 0; k--) wr('h38770 + k, 'hF000 + k * 17);
    wr('h38000, 'h29);
    @(negedge clk);

    // R9: strobe low, command values on the bus
    curReq = "R9";
    wrEn = 1'b0;
    wrAddr = AW'('h555); wrData = DW'('hAA); @(negedge clk);
    wrAddr = AW'('h2AA); wrData = DW'('h55); @(negedge clk);
    wrAddr = AW'('h18000); wrData = DW'('h25); @(negedge clk);
    wrAddr = AW'('h18000); wrData = DW'('h00); @(negedge clk);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule